// File: doc/BRIEF.md
# Bit-Test Branch and Loop-Count Resolver

This block settles the conditional-branch group of a small 8-bit processor core. A decoder upstream hands it one operation per request: branch when a chosen operand bit is one, branch when it is zero, branch and clear the bit when it is one, or decrement a counter and branch while the result is nonzero. With the operation come the operand kind, the operand byte already fetched, a bit index, a signed 8-bit displacement and the address of the instruction. The block returns the address to continue from, whether the branch was taken, a byte to store back with its write enable, and the number of processor clocks the instruction costs.

The cost depends on the operand kind and, for the short-direct and HL-indirect kinds, on whether the operand sits outside the fast internal RAM. For HL-indirect operands outside that RAM it adds the caller's external read and write wait counts. The core raises `start` for one clock; all results appear in registers one clock later together with a one-clock `done`, and they stay there until the next request.

Top module: `bit_branch_unit`

## Requirements
- R1: When the branch is not taken and the request is legal, `next_pc` = `pc_in` + length, modulo 65536. Length in bytes: op 0 (branch-if-set) is 4 for kind 1 and 3 for kinds 0, 2, 3, 4; ops 1 (branch-if-clear) and 2 (branch-and-clear) are 4 for kinds 0, 1, 3 and 3 for kinds 2, 4; op 3 (decrement-and-branch) is 3 for kind 0 and 2 for kinds 5, 6.
- R2: When the branch is taken, `next_pc` = `pc_in` + length + sign-extended `disp` (two's complement), modulo 65536.
- R3: Op 0 is taken when `operand[bit_sel]` is 1; op 1 is taken when that bit is 0. Neither writes back (`wb_en` = 0, `wb_data` = 0).
- R4: Op 2 is taken when `operand[bit_sel]` is 1, and only then sets `wb_en` = 1 with `wb_data` = `operand` with that bit cleared; otherwise `wb_en` = 0 and `wb_data` = 0.
- R5: Op 3 always sets `wb_en` = 1 with `wb_data` = `operand` − 1 (mod 256) and is taken when that value is nonzero; an operand of 0 gives 0xFF and a taken branch.
- R6: With `ext_mem` = 0, `cycles` is: op 0: 8, 11, 8, 9, 10; op 1: 10, 11, 8, 11, 10; op 2: 10, 12, 8, 12, 10 (for kinds 0..4 in order); op 3: 8 for kind 0 and 6 for kinds 5, 6.
- R7: With `ext_mem` = 1, kind 0 costs 9, 11, 12, 10 for ops 0..3; kind 4 costs 11 + `rd_waits` for ops 0 and 1 and 12 + `rd_waits` + `wr_waits` for op 2. `ext_mem`, `rd_waits` and `wr_waits` have no effect on other kinds.
- R8: Kind codes: 0 short-direct, 1 SFR, 2 accumulator, 3 PSW, 4 HL-indirect, 5 register B, 6 register C, 7 unused. Ops 0..2 accept kinds 0..4 and op 3 accepts kinds 0, 5, 6; any other pair sets `illegal` = 1, `next_pc` = `pc_in`, `taken` = 0, `wb_en` = 0, `wb_data` = 0, `cycles` = 0.
- R9: Results and `done` appear on the clock edge after the one that samples `start`; `done` is high for exactly that one clock per request, and results hold unchanged while `start` is low.
- R10: A synchronous reset (`rst_n` low at a clock edge) clears `done`, `taken`, `wb_en`, `illegal`, `next_pc`, `wb_data` and `cycles`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request strobe, one clock per instruction |
| op | input | 2 | Operation: 0 branch-if-set, 1 branch-if-clear, 2 branch-and-clear, 3 decrement-and-branch |
| kind | input | 3 | Operand kind code (see R8) |
| ext_mem | input | 1 | Operand lies outside internal high-speed RAM |
| operand | input | 8 | Operand byte as fetched |
| bit_sel | input | 3 | Bit index tested |
| disp | input | 8 | Signed branch displacement |
| pc_in | input | 16 | Address of the instruction |
| rd_waits | input | 4 | External read wait count |
| wr_waits | input | 4 | External write wait count |
| done | output | 1 | Results valid, one-clock pulse |
| next_pc | output | 16 | Address to continue from |
| taken | output | 1 | Branch was taken |
| wb_data | output | 8 | Byte to store back |
| wb_en | output | 1 | Store `wb_data` to the operand |
| cycles | output | 8 | Instruction clock count |
| illegal | output | 1 | Operation and kind do not form a valid instruction |

## Verification
The hardest corners to reach are the ones where two independent inputs must line up: a taken branch whose target crosses the top or bottom of the 16-bit address space, a decrement from zero that must both wrap the counter and branch, and an HL-indirect branch-and-clear outside fast RAM where both wait counts enter the cost. The stimulus sweeps every operation against every kind code with and without `ext_mem`, using nonzero waits, then places instructions at addresses near 0x0000 and 0xFFFF with extreme displacements so carry and borrow through the full width are exercised.

// File: rtl/bit_branch_pkg.sv
// Package: shared encodings for the bit-test branch resolver.
// Assumes op and kind codes are fixed by the decoder upstream.
package bit_branch_pkg;
    typedef enum logic [1:0] {
        OP_IF_SET   = 2'd0,
        OP_IF_CLEAR = 2'd1,
        OP_SET_CLR  = 2'd2,
        OP_DEC_LOOP = 2'd3
    } br_op_e;

    typedef enum logic [2:0] {
        K_SHORT = 3'd0,
        K_SFR   = 3'd1,
        K_ACC   = 3'd2,
        K_PSW   = 3'd3,
        K_HLIND = 3'd4,
        K_REGB  = 3'd5,
        K_REGC  = 3'd6,
        K_NONE  = 3'd7
    } op_kind_e;

    localparam int LEN_W = 3;
endpackage

// File: rtl/bit_branch_timing.sv
// Module: bit_branch_timing
// Looks up instruction length and clock cost for an op/kind pair and
// flags pairs that are not valid instructions.
// Assumes the wait counts are only meaningful for HL-indirect operands.
module bit_branch_timing
    import bit_branch_pkg::*;
#(
    parameter int WAIT_W = 4,
    parameter int CYC_W  = 8
) (
    input  logic [1:0]        op,
    input  logic [2:0]        kind,
    input  logic              ext_mem,
    input  logic [WAIT_W-1:0] rd_waits,
    input  logic [WAIT_W-1:0] wr_waits,
    output logic              legal,
    output logic [LEN_W-1:0]  len,
    output logic [CYC_W-1:0]  cyc
);
    localparam logic [CYC_W-1:0] HL_EXT_BASE_RD = CYC_W'(11);
    localparam logic [CYC_W-1:0] HL_EXT_BASE_RW = CYC_W'(12);

    logic [CYC_W-1:0] rd_ext;
    logic [CYC_W-1:0] wr_ext;

    assign rd_ext = CYC_W'(rd_waits);
    assign wr_ext = CYC_W'(wr_waits);

    // Legality and instruction length per op/kind pair.
    always_comb begin
        legal = 1'b0;
        len   = '0;
        unique case (br_op_e'(op))
            OP_IF_SET: begin
                legal = (kind <= K_HLIND);
                len   = (kind == K_SFR) ? LEN_W'(4) : LEN_W'(3);
            end
            OP_IF_CLEAR, OP_SET_CLR: begin
                legal = (kind <= K_HLIND);
                len   = (kind == K_ACC || kind == K_HLIND) ? LEN_W'(3) : LEN_W'(4);
            end
            OP_DEC_LOOP: begin
                legal = (kind == K_SHORT) || (kind == K_REGB) || (kind == K_REGC);
                len   = (kind == K_SHORT) ? LEN_W'(3) : LEN_W'(2);
            end
            default: ;
        endcase
        if (!legal) len = '0;
    end

    // Clock cost, including the slow-memory variants and wait states.
    always_comb begin
        cyc = '0;
        unique case (br_op_e'(op))
            OP_IF_SET: begin
                unique case (op_kind_e'(kind))
                    K_SHORT: cyc = ext_mem ? CYC_W'(9) : CYC_W'(8);
                    K_SFR:   cyc = CYC_W'(11);
                    K_ACC:   cyc = CYC_W'(8);
                    K_PSW:   cyc = CYC_W'(9);
                    K_HLIND: cyc = ext_mem ? HL_EXT_BASE_RD + rd_ext : CYC_W'(10);
                    default: cyc = '0;
                endcase
            end
            OP_IF_CLEAR: begin
                unique case (op_kind_e'(kind))
                    K_SHORT: cyc = ext_mem ? CYC_W'(11) : CYC_W'(10);
                    K_SFR:   cyc = CYC_W'(11);
                    K_ACC:   cyc = CYC_W'(8);
                    K_PSW:   cyc = CYC_W'(11);
                    K_HLIND: cyc = ext_mem ? HL_EXT_BASE_RD + rd_ext : CYC_W'(10);
                    default: cyc = '0;
                endcase
            end
            OP_SET_CLR: begin
                unique case (op_kind_e'(kind))
                    K_SHORT: cyc = ext_mem ? CYC_W'(12) : CYC_W'(10);
                    K_SFR:   cyc = CYC_W'(12);
                    K_ACC:   cyc = CYC_W'(8);
                    K_PSW:   cyc = CYC_W'(12);
                    K_HLIND: cyc = ext_mem ? HL_EXT_BASE_RW + rd_ext + wr_ext : CYC_W'(10);
                    default: cyc = '0;
                endcase
            end
            OP_DEC_LOOP: begin
                unique case (op_kind_e'(kind))
                    K_SHORT:        cyc = ext_mem ? CYC_W'(10) : CYC_W'(8);
                    K_REGB, K_REGC: cyc = CYC_W'(6);
                    default:        cyc = '0;
                endcase
            end
            default: cyc = '0;
        endcase
    end
endmodule

// File: rtl/bit_branch_cond.sv
// Module: bit_branch_cond
// Decides whether the branch is taken and forms the write-back byte.
// Assumes legality is checked by the caller; it only masks outputs.
module bit_branch_cond
    import bit_branch_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [1:0]                  op,
    input  logic                        legal,
    input  logic [DATA_W-1:0]           operand,
    input  logic [$clog2(DATA_W)-1:0]   bit_sel,
    output logic                        taken,
    output logic                        wb_en,
    output logic [DATA_W-1:0]           wb_data
);
    logic [DATA_W-1:0] sel_mask;
    logic              bit_val;
    logic [DATA_W-1:0] dec_val;

    // One-hot mask of the selected bit, one lane per data bit.
    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        assign sel_mask[i] = (bit_sel == i[$clog2(DATA_W)-1:0]);
    end

    assign bit_val = |(operand & sel_mask);
    assign dec_val = operand - DATA_W'(1);

    // Branch condition and write-back selection by operation.
    always_comb begin
        taken   = 1'b0;
        wb_en   = 1'b0;
        wb_data = '0;
        if (legal) begin
            unique case (br_op_e'(op))
                OP_IF_SET:   taken = bit_val;
                OP_IF_CLEAR: taken = !bit_val;
                OP_SET_CLR: begin
                    taken = bit_val;
                    if (bit_val) begin
                        wb_en   = 1'b1;
                        wb_data = operand & ~sel_mask;
                    end
                end
                OP_DEC_LOOP: begin
                    taken   = (dec_val != '0);
                    wb_en   = 1'b1;
                    wb_data = dec_val;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/bit_branch_pc.sv
// Module: bit_branch_pc
// Forms the fall-through and branch-target addresses and picks one.
// Assumes a zero length for illegal requests, so the address is unchanged.
module bit_branch_pc
    import bit_branch_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int DISP_W = 8
) (
    input  logic [PC_W-1:0]   pc_in,
    input  logic [LEN_W-1:0]  len,
    input  logic [DISP_W-1:0] disp,
    input  logic              taken,
    output logic [PC_W-1:0]   next_pc
);
    logic [PC_W-1:0] fall_pc;
    logic [PC_W-1:0] disp_ext;

    assign fall_pc  = pc_in + PC_W'(len);
    assign disp_ext = {{(PC_W-DISP_W){disp[DISP_W-1]}}, disp};

    // Select target or fall-through; addition wraps at the address width.
    always_comb begin
        next_pc = taken ? (fall_pc + disp_ext) : fall_pc;
    end
endmodule

// File: rtl/bit_branch_unit.sv
// Module: bit_branch_unit (top)
// Resolves one conditional-branch instruction per start strobe and
// registers all results, which hold until the next request.
// Assumes start is a one-clock strobe; reset is synchronous, active low.
module bit_branch_unit
    import bit_branch_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int DATA_W = 8,
    parameter int WAIT_W = 4,
    parameter int CYC_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [1:0]                op,
    input  logic [2:0]                kind,
    input  logic                      ext_mem,
    input  logic [DATA_W-1:0]         operand,
    input  logic [$clog2(DATA_W)-1:0] bit_sel,
    input  logic [7:0]                disp,
    input  logic [PC_W-1:0]           pc_in,
    input  logic [WAIT_W-1:0]         rd_waits,
    input  logic [WAIT_W-1:0]         wr_waits,
    output logic                      done,
    output logic [PC_W-1:0]           next_pc,
    output logic                      taken,
    output logic [DATA_W-1:0]         wb_data,
    output logic                      wb_en,
    output logic [CYC_W-1:0]          cycles,
    output logic                      illegal
);
    logic              c_legal;
    logic [LEN_W-1:0]  c_len;
    logic [CYC_W-1:0]  c_cyc;
    logic              c_taken;
    logic              c_wb_en;
    logic [DATA_W-1:0] c_wb_data;
    logic [PC_W-1:0]   c_next_pc;

    bit_branch_timing #(.WAIT_W(WAIT_W), .CYC_W(CYC_W)) u_timing (
        .op(op), .kind(kind), .ext_mem(ext_mem),
        .rd_waits(rd_waits), .wr_waits(wr_waits),
        .legal(c_legal), .len(c_len), .cyc(c_cyc)
    );

    bit_branch_cond #(.DATA_W(DATA_W)) u_cond (
        .op(op), .legal(c_legal), .operand(operand), .bit_sel(bit_sel),
        .taken(c_taken), .wb_en(c_wb_en), .wb_data(c_wb_data)
    );

    bit_branch_pc #(.PC_W(PC_W), .DISP_W(8)) u_pc (
        .pc_in(pc_in), .len(c_len), .disp(disp), .taken(c_taken),
        .next_pc(c_next_pc)
    );

    // Output registers: clear on reset, load on start, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done    <= 1'b0;
            next_pc <= '0;
            taken   <= 1'b0;
            wb_data <= '0;
            wb_en   <= 1'b0;
            cycles  <= '0;
            illegal <= 1'b0;
        end else begin
            done <= start;
            if (start) begin
                next_pc <= c_next_pc;
                taken   <= c_taken;
                wb_data <= c_wb_data;
                wb_en   <= c_wb_en;
                cycles  <= c_legal ? c_cyc : '0;
                illegal <= !c_legal;
            end
        end
    end

    // done follows a request by one clock and lasts one clock.
    assert_done_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);
    // Results are stable when no request was made.
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(next_pc) && $stable(cycles) && $stable(wb_data)));
    // Illegal requests leave the address unchanged and have no side effect.
    assert_illegal_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !c_legal) |=> (illegal && next_pc == $past(pc_in) && !taken && !wb_en));
    // Write-back from bit ops only when the test-and-clear branch is taken.
    assert_wb_only_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && c_legal && op != 2'd3) |=> (wb_en == ($past(op) == 2'd2 && taken)));
    // Decrement loop: branch exactly when the stored-back count is nonzero.
    assert_loop_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && c_legal && op == 2'd3) |=> (wb_en && taken == (wb_data != '0)));
endmodule

// File: tb/bit_branch_unit_test.sv
module bit_branch_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = '0;
    logic [2:0]  kind = '0;
    logic        ext_mem = 1'b0;
    logic [7:0]  operand = '0;
    logic [2:0]  bit_sel = '0;
    logic [7:0]  disp = '0;
    logic [15:0] pc_in = '0;
    logic [3:0]  rd_waits = '0;
    logic [3:0]  wr_waits = '0;
    logic        done;
    logic [15:0] next_pc;
    logic        taken;
    logic [7:0]  wb_data;
    logic        wb_en;
    logic [7:0]  cycles;
    logic        illegal;

    int n_tests = 0;
    int n_fail  = 0;

    bit_branch_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .kind(kind),
        .ext_mem(ext_mem), .operand(operand), .bit_sel(bit_sel), .disp(disp),
        .pc_in(pc_in), .rd_waits(rd_waits), .wr_waits(wr_waits),
        .done(done), .next_pc(next_pc), .taken(taken), .wb_data(wb_data),
        .wb_en(wb_en), .cycles(cycles), .illegal(illegal)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic bit m_legal(input int o, input int k);
        if (o < 3) return k <= 4;
        return k == 0 || k == 5 || k == 6;
    endfunction

    function automatic int m_len(input int o, input int k);
        if (!m_legal(o, k)) return 0;
        case (o)
            0: return (k == 1) ? 4 : 3;
            1, 2: return (k == 2 || k == 4) ? 3 : 4;
            default: return (k == 0) ? 3 : 2;
        endcase
    endfunction

    function automatic int m_cyc(input int o, input int k, input bit x, input int n, input int m);
        int t0[5] = '{8, 11, 8, 9, 10};
        int t1[5] = '{10, 11, 8, 11, 10};
        int t2[5] = '{10, 12, 8, 12, 10};
        if (!m_legal(o, k)) return 0;
        if (x && k == 0) begin
            case (o) 0: return 9; 1: return 11; 2: return 12; default: return 10; endcase
        end
        if (x && k == 4) return (o == 2) ? 12 + n + m : 11 + n;
        case (o)
            0: return t0[k];
            1: return t1[k];
            2: return t2[k];
            default: return (k == 0) ? 8 : 6;
        endcase
    endfunction

    // Issue one request, then check every output at the result cycle.
    task automatic run(input string tag, input int o, input int k, input bit x,
                       input int opd, input int b, input int d, input int pc,
                       input int n, input int m);
        bit        lg, tk, we;
        int        wd, ln;
        logic [15:0] npc;
        logic [7:0]  dec;
        @(negedge clk);
        op = 2'(o); kind = 3'(k); ext_mem = x; operand = 8'(opd); bit_sel = 3'(b);
        disp = 8'(d); pc_in = 16'(pc); rd_waits = 4'(n); wr_waits = 4'(m);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lg = m_legal(o, k);
        ln = m_len(o, k);
        dec = 8'(opd) - 8'd1;
        tk = 0; we = 0; wd = 0;
        if (lg) begin
            case (o)
                0: tk = opd[b];
                1: tk = !opd[b];
                2: begin tk = opd[b]; we = tk; wd = tk ? (opd & ~(1 << b)) & 8'hFF : 0; end
                default: begin we = 1; wd = dec; tk = (dec != 0); end
            endcase
        end
        npc = 16'(pc) + 16'(ln);
        if (tk) npc = npc + {{8{d[7]}}, 8'(d)};
        chk(tag, "done", done, 1);
        chk(tag, "illegal", illegal, !lg);
        chk(tag, "taken", taken, tk);
        chk(tag, "next_pc", next_pc, npc);
        chk(tag, "wb_en", wb_en, we);
        chk(tag, "wb_data", wb_data, wd);
        chk(tag, "cycles", cycles, m_cyc(o, k, x, n, m));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10", "done", done, 0);
        chk("R10", "next_pc", next_pc, 0);
        chk("R10", "cycles", cycles, 0);
        chk("R10", "wb_en", wb_en, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_bit_tests();
        run("R3", 0, 2, 0, 8'h10, 4, 5, 16'h1000, 0, 0);
        run("R3", 0, 2, 0, 8'hEF, 4, 5, 16'h1000, 0, 0);
        run("R3", 1, 3, 0, 8'hEF, 4, -6, 16'h2000, 0, 0);
        run("R1", 1, 1, 0, 8'h01, 0, 7, 16'h2000, 0, 0);
        run("R1", 0, 1, 0, 8'h00, 7, 7, 16'h3000, 0, 0);
        run("R4", 2, 0, 0, 8'hFF, 7, 2, 16'h4000, 0, 0);
        run("R4", 2, 4, 0, 8'h7F, 7, 2, 16'h4000, 0, 0);
        run("R4", 2, 2, 0, 8'h81, 0, -128, 16'h4000, 0, 0);
    endtask

    task automatic t_loop();
        run("R5", 3, 5, 0, 8'h05, 0, -3, 16'h0500, 0, 0);
        run("R5", 3, 6, 0, 8'h01, 0, -3, 16'h0500, 0, 0);
        run("R5", 3, 0, 0, 8'h00, 0, 10, 16'h0500, 0, 0);
    endtask

    task automatic t_costs();
        for (int o = 0; o < 4; o++)
            for (int k = 0; k < 8; k++) begin
                run("R6", o, k, 0, 8'h5A, 3, 4, 16'h8000, 5, 9);
                run("R7", o, k, 1, 8'hA5, 3, 4, 16'h8000, 5, 9);
            end
        run("R7", 2, 4, 1, 8'h08, 3, 1, 16'h0100, 15, 15);
        run("R7", 1, 4, 1, 8'h00, 3, 1, 16'h0100, 15, 0);
    endtask

    task automatic t_illegal();
        run("R8", 3, 2, 0, 8'h03, 0, 9, 16'h1234, 0, 0);
        run("R8", 0, 5, 0, 8'hFF, 0, 9, 16'h4321, 0, 0);
        run("R8", 2, 7, 1, 8'hFF, 1, 9, 16'hABCD, 3, 3);
    endtask

    task automatic t_wrap();
        run("R2", 0, 1, 0, 8'h01, 0, 127, 16'hFFF0, 0, 0);
        run("R2", 1, 2, 0, 8'h00, 0, -128, 16'h0010, 0, 0);
        run("R1", 3, 0, 0, 8'h01, 0, 4, 16'hFFFE, 0, 0);
    endtask

    task automatic t_hold();
        logic [15:0] pc_keep;
        run("R9", 0, 0, 0, 8'h02, 1, 20, 16'h0700, 0, 0);
        pc_keep = next_pc;
        @(negedge clk);
        pc_in = 16'h9999; op = 2'd3; kind = 3'd5; operand = 8'h00;
        chk("R9", "done low", done, 0);
        repeat (3) @(negedge clk);
        chk("R9", "next_pc hold", next_pc, pc_keep);
        chk("R9", "cycles hold", cycles, 8);
        chk("R9", "wb_en hold", wb_en, 0);
    endtask

    initial begin
        t_reset();
        t_bit_tests();
        t_loop();
        t_costs();
        t_illegal();
        t_wrap();
        t_hold();
        t_reset();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #4000000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule